// File: doc/BRIEF.md
# Programmed-I/O Sector Buffer

This block sits on the controller side of a disk interface and stages one sector at a time between a device-side word stream and a host CPU that moves data itself through a 16-bit data port. The host first programs how many sectors it wants and then issues a read or write command. For each sector the block raises an interrupt when the sector is ready. The host then moves the whole sector as 256 back-to-back word accesses. After that, the block re-arms and prepares the next sector before it signals again.

For a read command, the device pushes 256 words into the buffer on a valid/ready input stream. The host is then interrupted and drains the buffer. For a write command, the host is interrupted straight away and fills the buffer. The block then pushes the 256 words out on a valid/ready output stream. The device side applies back-pressure by holding its ready low. An output word, once offered, stays put until it is taken. Input words are accepted only in cycles where both valid and ready are high. When the programmed count has been used up, busy drops and done is set.

Top module: `pio_sector_buf`

## Requirements
- R1: After reset, irq is 0, dev_in_ready and dev_out_valid are 0, and both the status register and the sector-count register read 0.
- R2: Register map on host_addr: 0 is the data port, 1 is command on write and status on read, and 2 is the sector count. A command write uses host_wdata[1:0], where 01 means read sectors and 10 means write sectors. A command is accepted only when the block is not busy, the code is 01 or 10, and the count is non-zero; otherwise it is ignored. Count writes are ignored while busy.
- R3: Read command: dev_in_ready is high only while a sector is being filled, and exactly 256 words are taken per sector. The next 256 reads of the data port then return those words in arrival order.
- R4: Write command: irq is high in the cycle after the command is accepted. The 256 data-port writes of a sector then leave on the output stream in the order they were written.
- R5: While dev_out_valid is high and dev_out_ready is low, dev_out_valid and dev_out_data hold their values in the next cycle.
- R6: irq rises only when a sector window opens. It is cleared by a status read or by the first valid data-port access of that sector, whichever comes first.
- R7: Exactly one irq is raised per sector. In a multi-sector command, the next irq comes only after the current sector has been fully moved: for reads, after the next fill completes; for writes, after the drain completes.
- R8: The count register decrements once per completed sector. When it reaches 0, busy falls and done is set. Done is cleared by the next accepted command.
- R9: A data-port access outside a sector window, or in the wrong direction for the command, is ignored. Such a read returns 0, and such a write leaves the buffer unchanged. Either one sets the overrun flag, which the next accepted command clears.
- R10: Status bits are bit0 busy, bit1 data-request, bit2 done, bit3 overrun and bit4 irq-pending. Data-request is high only while a sector is open to the host. When the block is not busy, both device streams are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for the selected register |
| irq | output | 1 | Sector-ready interrupt |
| dev_in_valid | input | 1 | Device word offered to the buffer |
| dev_in_ready | output | 1 | Buffer accepts a device word |
| dev_in_data | input | 16 | Device word |
| dev_out_valid | output | 1 | Buffer word offered to the device |
| dev_out_ready | input | 1 | Device accepts the word |
| dev_out_data | output | 16 | Buffer word to the device |

## Verification
Sector transfers are tried in both directions with random word contents, random gaps on the input valid and random stalls on the output ready. The gaps show that only real handshakes advance the fill. The stalls show that the output word is held under back-pressure. Each sector clears its interrupt by a randomly chosen method, either a status read or the first data access, which checks that both clear paths work without disturbing the data. Directed cases cover a zero count, an illegal command code, count writes while busy, and accesses that are out of window or in the wrong direction. Together they separate an ignored access from one that moves the pointer or corrupts the buffer.

// File: rtl/psb_pkg.sv
package psb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_HOST  = 2'd2,
    ST_DRAIN = 2'd3
  } psb_state_e;

  localparam logic [1:0] REG_DATA  = 2'd0;
  localparam logic [1:0] REG_CTRL  = 2'd1;
  localparam logic [1:0] REG_COUNT = 2'd2;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;

  localparam int unsigned STAT_BUSY = 0;
  localparam int unsigned STAT_DRQ  = 1;
  localparam int unsigned STAT_DONE = 2;
  localparam int unsigned STAT_OVR  = 3;
  localparam int unsigned STAT_IRQ  = 4;
  localparam int unsigned STAT_W    = 5;

  typedef struct packed {
    logic data_rd;
    logic data_wr;
    logic ctrl_rd;
    logic ctrl_wr;
    logic count_wr;
  } psb_strobe_t;

endpackage

// File: rtl/psb_secbuf.sv
module psb_secbuf #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/psb_hostif.sv
module psb_hostif
  import psb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 8
) (
  input  logic [1:0]         host_addr,
  input  logic               host_wr,
  input  logic               host_rd,
  output psb_strobe_t        strb,
  input  logic [STAT_W-1:0]  status,
  input  logic               rd_window,
  input  logic [CNT_W-1:0]   sec_left,
  input  logic [DATA_W-1:0]  buf_rdata,
  output logic [DATA_W-1:0]  host_rdata
);

  logic rd_only;
  assign rd_only = host_rd && !host_wr;

  always_comb begin
    strb          = '0;
    strb.data_rd  = rd_only && (host_addr == REG_DATA);
    strb.data_wr  = host_wr && (host_addr == REG_DATA);
    strb.ctrl_rd  = rd_only && (host_addr == REG_CTRL);
    strb.ctrl_wr  = host_wr && (host_addr == REG_CTRL);
    strb.count_wr = host_wr && (host_addr == REG_COUNT);
  end

  always_comb begin
    unique case (host_addr)
      REG_DATA:  host_rdata = rd_window ? buf_rdata : '0;
      REG_CTRL:  host_rdata = {{(DATA_W-STAT_W){1'b0}}, status};
      REG_COUNT: host_rdata = {{(DATA_W-CNT_W){1'b0}}, sec_left};
      default:   host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/psb_seq.sv
module psb_seq
  import psb_pkg::*;
#(
  parameter int unsigned WORDS = 256,
  parameter int unsigned CNT_W = 8,
  localparam int unsigned PTR_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  psb_strobe_t      strb,
  input  logic [1:0]       op,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             dev_in_valid,
  input  logic             dev_out_ready,
  output logic             dev_in_ready,
  output logic             dev_out_valid,
  output logic             busy,
  output logic             drq,
  output logic             dir_wr,
  output logic             irq,
  output logic             done,
  output logic             ovr,
  output logic [CNT_W-1:0] sec_left,
  output logic [PTR_W-1:0] ptr,
  output logic             buf_we,
  output logic             buf_from_host
);

  psb_state_e st;
  logic in_hs, out_hs, host_ok, bad_acc, last_word, final_sec, go;
  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    in_hs     = (st == ST_FILL) && dev_in_valid;
    out_hs    = (st == ST_DRAIN) && dev_out_ready;
    host_ok   = (st == ST_HOST) && (dir_wr ? strb.data_wr : strb.data_rd);
    bad_acc   = (strb.data_rd || strb.data_wr) && !host_ok;
    last_word = (ptr == PTR_W'(WORDS - 1));
    ptr_nxt   = last_word ? '0 : ptr + PTR_W'(1);
    final_sec = (sec_left == CNT_W'(1));
    go        = strb.ctrl_wr && (st == ST_IDLE) && (sec_left != '0) &&
                ((op == OP_READ) || (op == OP_WRITE));
  end

  assign busy          = (st != ST_IDLE);
  assign drq           = (st == ST_HOST);
  assign dev_in_ready  = (st == ST_FILL);
  assign dev_out_valid = (st == ST_DRAIN);
  assign buf_we        = in_hs || (host_ok && dir_wr);
  assign buf_from_host = (st == ST_HOST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      dir_wr   <= 1'b0;
      irq      <= 1'b0;
      done     <= 1'b0;
      ovr      <= 1'b0;
      sec_left <= '0;
      ptr      <= '0;
    end else begin
      if (strb.count_wr && (st == ST_IDLE)) sec_left <= cnt_wdata;
      if (bad_acc) ovr <= 1'b1;
      if (strb.ctrl_rd || host_ok) irq <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            dir_wr <= (op == OP_WRITE);
            ptr    <= '0;
            done   <= 1'b0;
            ovr    <= 1'b0;
            if (op == OP_WRITE) begin
              st  <= ST_HOST;
              irq <= 1'b1;
            end else begin
              st <= ST_FILL;
            end
          end
        end
        ST_FILL: begin
          if (in_hs) begin
            ptr <= ptr_nxt;
            if (last_word) begin
              st  <= ST_HOST;
              irq <= 1'b1;
            end
          end
        end
        ST_HOST: begin
          if (host_ok) begin
            ptr <= ptr_nxt;
            if (last_word) begin
              if (dir_wr) begin
                st <= ST_DRAIN;
              end else begin
                sec_left <= sec_left - CNT_W'(1);
                if (final_sec) begin
                  st   <= ST_IDLE;
                  done <= 1'b1;
                end else begin
                  st <= ST_FILL;
                end
              end
            end
          end
        end
        ST_DRAIN: begin
          if (out_hs) begin
            ptr <= ptr_nxt;
            if (last_word) begin
              sec_left <= sec_left - CNT_W'(1);
              if (final_sec) begin
                st   <= ST_IDLE;
                done <= 1'b1;
              end else begin
                st  <= ST_HOST;
                irq <= 1'b1;
              end
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pio_sector_buf.sv
module pio_sector_buf
  import psb_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned WORDS  = 256,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned PTR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  input  logic              dev_in_valid,
  output logic              dev_in_ready,
  input  logic [DATA_W-1:0] dev_in_data,
  output logic              dev_out_valid,
  input  logic              dev_out_ready,
  output logic [DATA_W-1:0] dev_out_data
);

  psb_strobe_t       strb;
  logic              busy_w, drq_w, dir_wr_w, done_w, ovr_w;
  logic              buf_we, buf_from_host;
  logic [CNT_W-1:0]  sec_left;
  logic [PTR_W-1:0]  ptr;
  logic [DATA_W-1:0] buf_wdata, buf_rdata;
  logic [STAT_W-1:0] status;

  always_comb begin
    status            = '0;
    status[STAT_BUSY] = busy_w;
    status[STAT_DRQ]  = drq_w;
    status[STAT_DONE] = done_w;
    status[STAT_OVR]  = ovr_w;
    status[STAT_IRQ]  = irq;
  end

  assign buf_wdata    = buf_from_host ? host_wdata : dev_in_data;
  assign dev_out_data = buf_rdata;

  psb_hostif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_hostif (
    .host_addr (host_addr),
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .strb      (strb),
    .status    (status),
    .rd_window (drq_w && !dir_wr_w),
    .sec_left  (sec_left),
    .buf_rdata (buf_rdata),
    .host_rdata(host_rdata)
  );

  psb_seq #(.WORDS(WORDS), .CNT_W(CNT_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .op           (host_wdata[1:0]),
    .cnt_wdata    (host_wdata[CNT_W-1:0]),
    .dev_in_valid (dev_in_valid),
    .dev_out_ready(dev_out_ready),
    .dev_in_ready (dev_in_ready),
    .dev_out_valid(dev_out_valid),
    .busy         (busy_w),
    .drq          (drq_w),
    .dir_wr       (dir_wr_w),
    .irq          (irq),
    .done         (done_w),
    .ovr          (ovr_w),
    .sec_left     (sec_left),
    .ptr          (ptr),
    .buf_we       (buf_we),
    .buf_from_host(buf_from_host)
  );

  psb_secbuf #(.DATA_W(DATA_W), .DEPTH(WORDS)) u_buf (
    .clk  (clk),
    .we   (buf_we),
    .waddr(ptr),
    .wdata(buf_wdata),
    .raddr(ptr),
    .rdata(buf_rdata)
  );

endmodule

// File: rtl/psb_chk.sv
module psb_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq,
  input logic              drq,
  input logic              busy,
  input logic              done,
  input logic              dev_in_ready,
  input logic              dev_out_valid,
  input logic              dev_out_ready,
  input logic [DATA_W-1:0] dev_out_data
);

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_out_valid && !dev_out_ready |=> dev_out_valid && $stable(dev_out_data));

  // R6
  irq_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> drq);

  // R6
  irq_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $rose(drq));

  // R8
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  idle_streams_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dev_in_ready && !dev_out_valid);

  // R3
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_in_ready && dev_out_valid) && !(drq && (dev_in_ready || dev_out_valid)));

endmodule

bind pio_sector_buf psb_chk #(.DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .drq          (drq_w),
  .busy         (busy_w),
  .done         (done_w),
  .dev_in_ready (dev_in_ready),
  .dev_out_valid(dev_out_valid),
  .dev_out_ready(dev_out_ready),
  .dev_out_data (dev_out_data)
);

// File: tb/tb_pio_sector_buf.sv
`timescale 1ns/1ps
module tb_pio_sector_buf;

  localparam int WORDS = 256;
  localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_CNT = 2'd2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        irq;
  logic        dev_in_valid = 1'b0;
  logic        dev_in_ready;
  logic [15:0] dev_in_data = '0;
  logic        dev_out_valid;
  logic        dev_out_ready = 1'b0;
  logic [15:0] dev_out_data;

  int vectors = 0;
  int fails = 0;
  bit finished = 0;
  bit ovr_m = 0;
  logic [15:0] exp_words [WORDS];

  always #5 clk = ~clk;

  pio_sector_buf dut (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] stat(input bit busy, input bit drq, input bit done,
                                       input bit ovr, input bit irqp);
    return {11'd0, irqp, ovr, done, drq, busy};
  endfunction

  task automatic hwr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask

  // device pushes one sector with random valid gaps (R3)
  task automatic feed_sector();
    int idx = 0;
    bit early = 0;
    bit hs;
    for (int i = 0; i < WORDS; i++) exp_words[i] = 16'($urandom);
    while (idx < WORDS) begin
      @(negedge clk);
      dev_in_valid = ($urandom % 4) != 0;
      dev_in_data  = exp_words[idx];
      #1 hs = dev_in_valid && dev_in_ready;
      if (irq) early = 1;
      @(posedge clk);
      if (hs) idx++;
    end
    @(negedge clk);
    dev_in_valid = 1'b0;
    #1;
    chk("R7", "irq silent during fill", 32'(early), 32'd0);
    chk("R3", "fill closed after 256 words", 32'(dev_in_ready), 32'd0);
    chk("R7", "irq after fill", 32'(irq), 32'd1);
  endtask

  task automatic host_read_sector(input bit by_status);
    logic [15:0] d;
    int bad = 0;
    if (by_status) begin
      hrd(A_CTRL, d);
      chk("R10", "status in read window", 32'(d), 32'(stat(1, 1, 0, ovr_m, 1)));
      chk("R6", "irq cleared by status read", 32'(irq), 32'd0);
    end
    for (int i = 0; i < WORDS; i++) begin
      hrd(A_DATA, d);
      if (d !== exp_words[i]) bad++;
      if (i == 0 && !by_status) chk("R6", "irq cleared by first data read", 32'(irq), 32'd0);
    end
    chk("R3", "read words mismatching", 32'(bad), 32'd0);
  endtask

  task automatic host_write_sector(input bit by_status, input bit abuse);
    logic [15:0] d;
    if (by_status) begin
      hrd(A_CTRL, d);
      chk("R10", "status in write window", 32'(d), 32'(stat(1, 1, 0, ovr_m, 1)));
      chk("R6", "irq cleared by status read", 32'(irq), 32'd0);
    end
    if (abuse) begin
      hrd(A_DATA, d);
      ovr_m = 1;
      chk("R9", "wrong-direction read returns 0", 32'(d), 32'd0);
      if (!by_status) chk("R6", "ignored access keeps irq", 32'(irq), 32'd1);
    end
    for (int i = 0; i < WORDS; i++) begin
      exp_words[i] = 16'($urandom);
      hwr(A_DATA, exp_words[i]);
      if (i == 0 && !by_status) chk("R6", "irq cleared by first data write", 32'(irq), 32'd0);
    end
    if (abuse) begin
      hwr(A_DATA, 16'hDEAD);
      hrd(A_CTRL, d);
      chk("R9", "extra write sets overrun", 32'(d[3]), 32'd1);
      chk("R10", "drq low after 256 words", 32'(d[1]), 32'd0);
    end
  endtask

  // device drains one sector with random stalls (R4, R5)
  task automatic drain_sector();
    int idx = 0, bad = 0, moved = 0;
    bit stalled = 0, early = 0;
    logic [15:0] held = '0;
    while (idx < WORDS) begin
      @(negedge clk);
      dev_out_ready = ($urandom % 3) != 0;
      #1;
      if (irq) early = 1;
      if (stalled && (!dev_out_valid || dev_out_data !== held)) moved++;
      stalled = dev_out_valid && !dev_out_ready;
      held = dev_out_data;
      if (dev_out_valid && dev_out_ready) begin
        if (dev_out_data !== exp_words[idx]) bad++;
        @(posedge clk);
        idx++;
      end else begin
        @(posedge clk);
      end
    end
    @(negedge clk);
    dev_out_ready = 1'b0;
    #1;
    chk("R5", "output moved under stall", 32'(moved), 32'd0);
    chk("R4", "drained words mismatching", 32'(bad), 32'd0);
    chk("R7", "irq silent during drain", 32'(early), 32'd0);
    chk("R4", "stream idle after 256 words", 32'(dev_out_valid), 32'd0);
  endtask

  task automatic run_cmd(input bit is_wr, input int nsec, input bit abuse);
    logic [15:0] d;
    hwr(A_CNT, 16'(nsec));
    hwr(A_CTRL, is_wr ? 16'h0002 : 16'h0001);
    ovr_m = 0;
    if (is_wr) begin
      chk("R4", "irq right after write command", 32'(irq), 32'd1);
    end else begin
      chk("R3", "fill opens after read command", 32'(dev_in_ready), 32'd1);
      hrd(A_CTRL, d);
      chk("R8", "status after read accept", 32'(d), 32'(stat(1, 0, 0, 0, 0)));
    end
    for (int s = 0; s < nsec; s++) begin
      bit by_status = ($urandom % 2) == 1;
      if (is_wr) begin
        if (s == 0 && abuse) begin
          hwr(A_CNT, 16'd99);
          hrd(A_CNT, d);
          chk("R2", "count write ignored while busy", 32'(d), 32'(nsec));
        end
        host_write_sector(by_status, abuse && s == 0);
        drain_sector();
        chk("R7", "irq after drain", 32'(irq), 32'(s != nsec - 1));
      end else begin
        feed_sector();
        host_read_sector(by_status);
        chk("R7", "irq low after host drain", 32'(irq), 32'd0);
        if (abuse && s == 0 && nsec > 1) begin
          hrd(A_DATA, d);
          ovr_m = 1;
          chk("R9", "read beyond 256 words returns 0", 32'(d), 32'd0);
        end
      end
      hrd(A_CNT, d);
      chk("R8", "count after sector", 32'(d), 32'(nsec - s - 1));
    end
    hrd(A_CTRL, d);
    chk("R8", "status at completion", 32'(d), 32'(stat(0, 0, 1, ovr_m, 0)));
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5EC7_0B1F));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "irq/ready/valid at reset", {29'd0, irq, dev_in_ready, dev_out_valid}, 32'd0);
    hrd(A_CTRL, d);
    chk("R1", "status at reset", 32'(d), 32'd0);
    hrd(A_CNT, d);
    chk("R1", "count at reset", 32'(d), 32'd0);

    hwr(A_CTRL, 16'h0001);
    hrd(A_CTRL, d);
    chk("R2", "command with zero count ignored", 32'(d), 32'd0);
    hwr(A_CNT, 16'd2);
    hwr(A_CTRL, 16'h0003);
    hrd(A_CTRL, d);
    chk("R2", "illegal command code ignored", 32'(d), 32'd0);
    hrd(A_CNT, d);
    chk("R2", "count register holds", 32'(d), 32'd2);

    hrd(A_DATA, d);
    chk("R9", "idle data read returns 0", 32'(d), 32'd0);
    hrd(A_CTRL, d);
    chk("R9", "idle access sets overrun", 32'(d), 32'(stat(0, 0, 0, 1, 0)));

    run_cmd(1'b0, 2, 1'b1);
    run_cmd(1'b1, 3, 1'b1);
    for (int k = 0; k < 3; k++) run_cmd(1'($urandom), 1 + int'($urandom % 2), 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule